// File: doc/BRIEF.md
# Level-Order Tree Cost Search Engine

The block holds a byte-wide memory that software fills through a plain write port with a tree of nodes. Each node takes three consecutive bytes: its value first, then the address of its left child, then the address of its right child. A child address of all ones (8'hFF) means the child is absent. After a one-cycle `start` pulse the engine walks the tree breadth-first from address 0. It gives every node the cost `value + depth * level_cost` and reports the smallest such cost once the walk is over.

The queue of pending node addresses is a line of registers. A push shifts the whole line by one place, and a front-position register selects the oldest entry. Depth is tracked without storing it per node. A marker entry of 8'hFF ends each level in the queue. Popping the marker increments the depth and re-queues the marker behind the next level, unless the queue has run dry, in which case the walk is over. Nodes are handled by a three-phase sequence:

- pop and cost the head;
- fetch the left field;
- fetch the right field.

A marker takes one cycle. `busy` is high for the whole walk. `done` pulses for one cycle at the end. If a push would exceed the queue depth, the walk stops with `overflow` set.

Top module: `levelorder_cost_search`

## Requirements
- R1: While reset is applied and right after it, `busy`, `done` and `overflow` are 0 and `min_cost` is all ones.
- R2: When idle, `wr_en` stores `wr_data` at `wr_addr`. A node at address a holds its value at a, its left child address at a+1 and its right child address at a+2, modulo 256. The value 8'hFF in a child field means "no child".
- R3: A `start` pulse while idle does the following on that clock edge:
  - raises `busy` and clears `overflow`;
  - sets `min_cost` to all ones and depth to 0;
  - captures `level_cost` for the whole walk;
  - loads the queue with root address 0 followed by the level marker.
  A `start` while busy has no effect.
- R4: Popping the marker takes one cycle and increments depth. It re-queues the marker if entries remain; otherwise the walk ends on that edge.
- R5: A real node takes exactly three cycles, in this order:
  - pop it and compute `value + depth*level_cost` at full 16-bit width, replacing `min_cost` only when this cost is strictly smaller;
  - read the left field and push it unless it is 8'hFF;
  - read the right field and push it unless it is 8'hFF.
- R6: The walk takes 3 cycles per node plus 1 per marker popped. `busy` falls and `done` is high for exactly one cycle right after the final edge. `min_cost` then holds until the next accepted `start`.
- R7: If a push finds the queue holding QDEPTH entries (default 8), that push is dropped, `overflow` sets and the walk ends with a `done` pulse at that edge. `overflow` holds until the next start.
- R8: Writes presented while `busy` is high are ignored and leave the memory unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Memory write strobe, honoured only when idle |
| wr_addr | input | 8 | Memory write address |
| wr_data | input | 8 | Memory write byte |
| start | input | 1 | One-cycle pulse that begins a walk |
| level_cost | input | 8 | Cost added per level of depth, captured at start |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse when a walk ends |
| overflow | output | 1 | Last walk stopped because the queue was full |
| min_cost | output | 16 | Smallest cost found, all ones before any node |

## Verification
Counting the `start` edge as edge 0, the final pop or failing push lands on edge N, where N is three per node plus one per marker. `done` is therefore due in the cycle that follows edge N, and `busy` is due high in every cycle from edge 0 up to that cycle. The bench walks the written tree with its own behavioural queue to find N, the expected minimum and the overflow outcome. It then samples at each falling edge from edge 0 to N+1, checking `done` and `busy` every cycle, `min_cost` and `overflow` at N, and that `min_cost` is held one cycle later. Writes and `start` pulses injected mid-walk leave the expected values untouched, and a later rerun of the same tree confirms the memory was not altered.

// File: rtl/lcs_pkg.sv
package lcs_pkg;

    // Phase encoding: a down-counting sequence LEFT -> RIGHT -> POP while busy.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'b00,
        PH_POP   = 2'b01,
        PH_RIGHT = 2'b10,
        PH_LEFT  = 2'b11
    } phase_t;

endpackage

// File: rtl/lcs_mem.sv
module lcs_mem #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         we,
    input  logic [W-1:0] waddr,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] raddr,
    output logic [W-1:0] rdata
);
    localparam int DEPTH = 1 << W;

    logic [W-1:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store_q[waddr] <= wdata;
        end
    end

    assign rdata = store_q[raddr];

endmodule

// File: rtl/lcs_queue.sv
module lcs_queue #(
    parameter int W      = 8,
    parameter int QDEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         init,
    input  logic                         push,
    input  logic                         pop,
    input  logic [W-1:0]                 din,
    output logic [W-1:0]                 head,
    output logic [$clog2(QDEPTH+1)-1:0]  count
);
    localparam int          CNT_W  = $clog2(QDEPTH + 1);
    localparam int          IDX_W  = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
    localparam logic [W-1:0] MARKER = '1;

    typedef struct packed {
        logic [QDEPTH-1:0][W-1:0] ent;
        logic [CNT_W-1:0]         cnt;
    } qstate_t;

    qstate_t q_q, q_d;
    logic [IDX_W-1:0] front_idx;

    // Front position: the oldest entry sits at index cnt-1.
    assign front_idx = IDX_W'(q_q.cnt - CNT_W'(1));
    assign head      = (q_q.cnt != '0) ? q_q.ent[front_idx] : MARKER;
    assign count     = q_q.cnt;

    always_comb begin
        q_d = q_q;
        if (init) begin
            q_d.ent    = '0;
            q_d.ent[1] = '0;       // root address, oldest entry
            q_d.ent[0] = MARKER;   // end of level 0
            q_d.cnt    = CNT_W'(2);
        end else begin
            if (push) begin
                for (int i = 1; i < QDEPTH; i++) begin
                    q_d.ent[i] = q_q.ent[i-1];
                end
                q_d.ent[0] = din;
            end
            q_d.cnt = q_q.cnt + CNT_W'(push) - CNT_W'(pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q <= '0;
        end else begin
            q_q <= q_d;
        end
    end

    // R7: a growing push never meets a full line
    a_r7_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !init) |-> (q_q.cnt != CNT_W'(QDEPTH)));

    // R4: the sequencer never pops an empty line
    a_r4_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !init) |-> (q_q.cnt != '0));

endmodule

// File: rtl/levelorder_cost_search.sv
module levelorder_cost_search
    import lcs_pkg::*;
#(
    parameter int W      = 8,
    parameter int QDEPTH = 8,
    parameter int COST_W = 2 * W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [W-1:0]      wr_addr,
    input  logic [W-1:0]      wr_data,
    input  logic              start,
    input  logic [W-1:0]      level_cost,
    output logic              busy,
    output logic              done,
    output logic              overflow,
    output logic [COST_W-1:0] min_cost
);
    localparam int           CNT_W = $clog2(QDEPTH + 1);
    localparam logic [W-1:0] NULLP = '1;

    typedef struct packed {
        phase_t              ph;
        logic                busy;
        logic                done;
        logic                ovf;
        logic [W-1:0]        node;
        logic [W-1:0]        depth;
        logic [W-1:0]        lc;
        logic [COST_W-1:0]   minc;
    } st_t;

    localparam st_t ST_RST = '{ph: PH_IDLE, busy: 1'b0, done: 1'b0, ovf: 1'b0,
                               node: '0, depth: '0, lc: '0, minc: '1};

    st_t s_q, s_d;

    logic              mem_we;
    logic [W-1:0]      rd_addr;
    logic [W-1:0]      rd_data;
    logic              q_init, q_push, q_pop;
    logic [W-1:0]      q_din;
    logic [W-1:0]      q_head;
    logic [CNT_W-1:0]  q_cnt;
    logic [COST_W-1:0] node_cost;
    logic              q_full;

    assign mem_we = wr_en && !s_q.busy;

    lcs_mem #(.W(W)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    lcs_queue #(.W(W), .QDEPTH(QDEPTH)) u_queue (
        .clk   (clk),
        .rst_n (rst_n),
        .init  (q_init),
        .push  (q_push),
        .pop   (q_pop),
        .din   (q_din),
        .head  (q_head),
        .count (q_cnt)
    );

    // Read address follows the phase: head on pop, then node+1, node+2.
    always_comb begin
        unique case (s_q.ph)
            PH_LEFT:  rd_addr = s_q.node + W'(1);
            PH_RIGHT: rd_addr = s_q.node + W'(2);
            default:  rd_addr = q_head;
        endcase
    end

    assign node_cost = COST_W'(rd_data) + COST_W'(s_q.depth) * COST_W'(s_q.lc);
    assign q_full    = (q_cnt == CNT_W'(QDEPTH));

    always_comb begin
        s_d    = s_q;
        s_d.done = 1'b0;
        q_init = 1'b0;
        q_push = 1'b0;
        q_pop  = 1'b0;
        q_din  = rd_data;
        unique case (s_q.ph)
            PH_IDLE: begin
                if (start) begin
                    s_d.ph    = PH_POP;
                    s_d.busy  = 1'b1;
                    s_d.ovf   = 1'b0;
                    s_d.depth = '0;
                    s_d.minc  = '1;
                    s_d.lc    = level_cost;
                    q_init    = 1'b1;
                end
            end
            PH_POP: begin
                q_pop = 1'b1;
                if (q_head == NULLP) begin
                    s_d.depth = s_q.depth + W'(1);
                    if (q_cnt > CNT_W'(1)) begin
                        q_push = 1'b1;
                        q_din  = NULLP;
                    end else begin
                        s_d.ph   = PH_IDLE;
                        s_d.busy = 1'b0;
                        s_d.done = 1'b1;
                    end
                end else begin
                    s_d.node = q_head;
                    s_d.ph   = PH_LEFT;
                    if (node_cost < s_q.minc) begin
                        s_d.minc = node_cost;
                    end
                end
            end
            PH_LEFT, PH_RIGHT: begin
                s_d.ph = (s_q.ph == PH_LEFT) ? PH_RIGHT : PH_POP;
                if (rd_data != NULLP) begin
                    if (q_full) begin
                        s_d.ph   = PH_IDLE;
                        s_d.busy = 1'b0;
                        s_d.done = 1'b1;
                        s_d.ovf  = 1'b1;
                    end else begin
                        q_push = 1'b1;
                    end
                end
            end
            default: s_d = s_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= ST_RST;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy     = s_q.busy;
    assign done     = s_q.done;
    assign overflow = s_q.ovf;
    assign min_cost = s_q.minc;

    // R6: done is a single-cycle pulse and never overlaps busy
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R6: result is held while idle and no start arrives
    a_r6_min_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(min_cost));

    // R7: overflow only rises together with the end of a walk
    a_r7_ovf_ends: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> done);

    // R5: the running minimum never increases within a walk
    a_r5_min_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (min_cost <= $past(min_cost)));

    // R5: the right field is fetched only right after the left one
    a_r5_phase_order: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_RIGHT) |-> ($past(s_q.ph) == PH_LEFT));

endmodule

// File: tb/sim_levelorder_cost_search.sv
`timescale 1ns/1ps
module sim_levelorder_cost_search;

    localparam int QD = 8;   // default queue depth of the design (R7)

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        start = 1'b0;
    logic [7:0]  level_cost = '0;
    logic        busy, done, overflow;
    logic [15:0] min_cost;

    int n_chk  = 0;
    int n_fail = 0;
    bit [7:0] ref_mem [256];

    always #2 clk = ~clk;   // 250 MHz

    levelorder_cost_search u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .start(start), .level_cost(level_cost),
        .busy(busy), .done(done), .overflow(overflow), .min_cost(min_cost)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R2: idle write of one byte
    task automatic wr_byte(input int a, input int v);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = 8'(a);
        wr_data = 8'(v);
        @(negedge clk);
        wr_en = 1'b0;
        ref_mem[a[7:0]] = 8'(v);
    endtask

    task automatic put_node(input int a, input int v, input int l, input int r);
        wr_byte(a, v);
        wr_byte(a + 1, l);
        wr_byte(a + 2, r);
    endtask

    // Behavioural breadth-first walk: cycle count, minimum, overflow.
    task automatic model(input int lc, output int ncyc, output int mn, output bit ovf);
        int q[$];
        int depth;
        bit fin;
        q = {};
        q.push_back(0);
        q.push_back(255);
        depth = 0; ncyc = 0; mn = 65535; ovf = 1'b0; fin = 1'b0;
        while (!fin) begin
            int h;
            h = q.pop_front();
            ncyc++;
            if (h == 255) begin
                depth++;
                if (q.size() > 0) q.push_back(255);
                else fin = 1'b1;
            end else begin
                int c;
                c = int'(ref_mem[h[7:0]]) + depth * lc;
                if (c < mn) mn = c;
                for (int f = 1; f <= 2 && !fin; f++) begin
                    int ch;
                    ch = int'(ref_mem[8'(h + f)]);
                    ncyc++;
                    if (ch != 255) begin
                        if (q.size() >= QD) begin
                            ovf = 1'b1;
                            fin = 1'b1;
                        end else begin
                            q.push_back(ch);
                        end
                    end
                end
            end
        end
    endtask

    // One walk; optional write and start injected at cycle inj (R8, R3).
    task automatic run(input int lc, input int inj, input int ia, input int iv, input bit istart);
        int n, mn;
        bit ovf;
        model(lc, n, mn, ovf);
        @(negedge clk);
        start = 1'b1;
        level_cost = 8'(lc);
        for (int k = 0; k <= n + 1; k++) begin
            @(negedge clk);
            check(done == (k == n), "R6 done timing", done, (k == n));
            check(busy == (k < n), "R4/R5 busy duration", busy, (k < n));
            if (k == n) begin
                check(min_cost == 16'(mn), "R5 min_cost", min_cost, mn);
                check(overflow == ovf, "R7 overflow", overflow, ovf);
            end
            if (k == n + 1) begin
                check(min_cost == 16'(mn), "R6 min_cost held", min_cost, mn);
            end
            start   = (k == inj) && istart;
            level_cost = (k == inj) ? 8'd0 : 8'(lc);
            wr_en   = (k == inj);
            wr_addr = 8'(ia);
            wr_data = 8'(iv);
        end
        start = 1'b0;
        wr_en = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL R6 watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        check(busy == 1'b0, "R1 busy", busy, 0);
        check(done == 1'b0, "R1 done", done, 0);
        check(overflow == 1'b0, "R1 overflow", overflow, 0);
        check(min_cost == 16'hFFFF, "R1 min_cost", min_cost, 16'hFFFF);
        rst_n = 1'b1;
        @(negedge clk);
        check(min_cost == 16'hFFFF, "R1 min_cost after release", min_cost, 16'hFFFF);

        // R2: three-level tree with null fields
        put_node(0, 200, 3, 6);
        put_node(3, 50, 9, 255);
        put_node(6, 120, 12, 15);
        put_node(9, 10, 255, 255);
        put_node(12, 5, 255, 255);
        put_node(15, 90, 255, 255);

        run(20, -1, 0, 0, 1'b0);    // R5 deepest cheapest node wins
        run(0, -1, 0, 0, 1'b0);     // R5 depth irrelevant
        run(100, -1, 0, 0, 1'b0);   // R5 shallow node wins
        // R8 write to node 12 value during walk, R3 start while busy
        run(20, 2, 12, 0, 1'b1);
        run(20, -1, 0, 0, 1'b0);    // R8 memory unchanged after walk

        // R4/R6: single node, one marker at the end
        put_node(0, 33, 255, 255);
        run(9, -1, 0, 0, 1'b0);

        // R7: self-referencing root grows the queue until it is full
        put_node(0, 7, 0, 0);
        run(3, -1, 0, 0, 1'b0);

        // R7/R3: overflow cleared by the next start
        put_node(0, 40, 255, 255);
        run(1, -1, 0, 0, 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule